// File: doc/BRIEF.md
# Chunk Conflict Detection Unit

This block splits one thread's execution into chunks and decides when the current chunk must end. It keeps two approximate membership sets keyed by cache line address. The read set takes the line of each retired load, and the write set takes the line of each store once that store is globally observed. Incoming coherence snoops and lines leaving the second-level cache are checked against both sets. A hit under a conflicting access type ends the chunk. A chunk also ends on an exception, a TLB invalidation, an explicit end request, or when the retired-instruction counter runs out of range.

Each line address first waits one cycle in a holding register before it reaches its set. This lets the set update take a single cycle even when the tag bits arrive late. Snoops and evictions are compared exactly against the held addresses as well as against the sets, so the holding delay cannot hide a conflict. When a chunk ends, the unit gives a one-cycle pulse with a 4-bit cause code and the number of instructions retired in the chunk. In the same edge it empties both sets and restarts the counter.

Top module: `chunk_conflict_unit`

## Requirements
- R1: A retired load line presented in cycle t is visible to snoop and eviction lookups from cycle t+1 on, first through the holding register and from t+2 through the read set. A lookup in cycle t itself does not see it.
- R2: A globally observed store line follows the same timing into the write set.
- R3: A read snoop (snp_write_i=0) is checked only against the write set. A hit gives cause code 1 (remote read after local write). A read snoop that hits only the read set has no effect.
- R4: A write snoop (snp_write_i=1) that hits only the read set gives code 2. One that hits only the write set gives code 3. One that hits both sets gives code 4.
- R5: An eviction line that hits either set ends the chunk with code 5.
- R6: exc_i gives code 6, tlb_inval_i gives code 7 and end_req_i gives code 8. When several are raised together, exception wins over TLB invalidation, and TLB invalidation wins over the explicit request.
- R7: When several causes fall in one cycle, a snoop conflict wins over an eviction hit, an eviction hit wins over a system event, and a system event wins over counter overflow.
- R8: retire_i advances the instruction counter. The reported size includes a retirement in the ending cycle, unless R9 applies.
- R9: A retirement that arrives while the counter holds its maximum value ends the chunk. The cause is code 9 unless a higher cause is present. The size reported is that maximum, and the retirement counts as the first instruction of the next chunk.
- R10: Ending a chunk empties both sets and drops addresses already held. Lines presented in the ending cycle belong to the new chunk.
- R11: term_o pulses in the cycle after the cause. reason_o and size_o read 0 in every cycle without a pulse.
- R12: Reset empties both sets and the holding registers, clears the counter, and drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid_i | input | 1 | A load retired with line ld_line_i |
| ld_line_i | input | LINE_W | Line address of the retired load |
| st_valid_i | input | 1 | A store became globally observed |
| st_line_i | input | LINE_W | Line address of that store |
| retire_i | input | 1 | One instruction retired this cycle |
| snp_valid_i | input | 1 | Snoop present |
| snp_write_i | input | 1 | Snoop is a remote write (1) or read (0) |
| snp_line_i | input | LINE_W | Snooped line address |
| evict_valid_i | input | 1 | Line leaving the second-level cache |
| evict_line_i | input | LINE_W | Evicted line address |
| exc_i | input | 1 | Exception, interrupt, far call or far return |
| tlb_inval_i | input | 1 | TLB invalidation |
| end_req_i | input | 1 | Explicit chunk end instruction |
| term_o | output | 1 | Chunk ended (one-cycle pulse) |
| reason_o | output | 4 | Cause code, 0 when term_o is low |
| size_o | output | CS_W | Instructions in the ended chunk, 0 when term_o is low |

## Verification
The bench drives line addresses whose two hash positions do not overlap. Every expected hit or miss is therefore exact. A snoop is placed in the cycle right after a store, when the line exists only in the holding register. A design that skipped that comparison would miss this conflict. A load and a snoop for the same line are sent together to confirm that the lookup does not see the line too early. A snoop follows an event that ended the chunk in the same cycle as a load, to catch a design that loses lines presented on the ending edge. All cause sources are raised together to check the order of precedence. The counter is run up to its limit with a small counter width, which exposes an off-by-one in the reported size and a lost carry-over retirement.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

  typedef enum logic [3:0] {
    RSN_NONE      = 4'd0,
    RSN_RD_AFT_WR = 4'd1,
    RSN_WR_AFT_RD = 4'd2,
    RSN_WR_AFT_WR = 4'd3,
    RSN_WR_BOTH   = 4'd4,
    RSN_EVICT     = 4'd5,
    RSN_EXCEPT    = 4'd6,
    RSN_TLB_INVAL = 4'd7,
    RSN_EXPLICIT  = 4'd8,
    RSN_SIZE_OVF  = 4'd9
  } reason_e;

  // Snoop conflict class: read snoops see only the write set.
  function automatic reason_e snoop_reason(input logic is_wr,
                                           input logic r_hit,
                                           input logic w_hit);
    reason_e r;
    r = RSN_NONE;
    if (!is_wr) begin
      if (w_hit) r = RSN_RD_AFT_WR;
    end else if (r_hit && w_hit) begin
      r = RSN_WR_BOTH;
    end else if (r_hit) begin
      r = RSN_WR_AFT_RD;
    end else if (w_hit) begin
      r = RSN_WR_AFT_WR;
    end
    return r;
  endfunction

  // Full priority: snoop conflict, eviction, system events, overflow.
  function automatic reason_e pick_reason(input reason_e snp_r,
                                          input logic ev_hit,
                                          input logic exc,
                                          input logic tlb,
                                          input logic req,
                                          input logic ovf);
    reason_e r;
    if (snp_r != RSN_NONE) r = snp_r;
    else if (ev_hit)       r = RSN_EVICT;
    else if (exc)          r = RSN_EXCEPT;
    else if (tlb)          r = RSN_TLB_INVAL;
    else if (req)          r = RSN_EXPLICIT;
    else if (ovf)          r = RSN_SIZE_OVF;
    else                   r = RSN_NONE;
    return r;
  endfunction

endpackage

// File: rtl/ccu_addr_stage.sv
module ccu_addr_stage #(
  parameter int LINE_W = 26,
  parameter int NQ     = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid_i,
  input  logic [LINE_W-1:0]           in_line_i,
  input  logic [NQ-1:0][LINE_W-1:0]   qry_line_i,
  output logic                        pend_valid_o,
  output logic [LINE_W-1:0]           pend_line_o,
  output logic [NQ-1:0]               hit_o
);

  logic              held_v;
  logic [LINE_W-1:0] held_line;

  // The held entry is always replaced; on a chunk end the filter drops it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_v    <= 1'b0;
      held_line <= '0;
    end else begin
      held_v    <= in_valid_i;
      held_line <= in_line_i;
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_cmp
    assign hit_o[q] = held_v && (held_line == qry_line_i[q]);
  end

  assign pend_valid_o = held_v;
  assign pend_line_o  = held_line;

endmodule

// File: rtl/ccu_bloom.sv
module ccu_bloom #(
  parameter int LINE_W    = 26,
  parameter int FILT_BITS = 512,
  parameter int NQ        = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr_i,
  input  logic                        ins_valid_i,
  input  logic [LINE_W-1:0]           ins_line_i,
  input  logic [NQ-1:0][LINE_W-1:0]   qry_line_i,
  output logic [NQ-1:0]               hit_o,
  output logic                        occupied_o
);

  localparam int IDX_W = $clog2(FILT_BITS);

  // Fold: line bit i lands on index bit (i mod IDX_W).
  function automatic logic [IDX_W-1:0] hash_a(input logic [LINE_W-1:0] line);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int i = 0; i < LINE_W; i++) begin
      h[IDX_W'(i % IDX_W)] ^= line[i];
    end
    return h;
  endfunction

  // Scrambled fold: line bit i lands on index bit ((5*i+3) mod IDX_W).
  function automatic logic [IDX_W-1:0] hash_b(input logic [LINE_W-1:0] line);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int i = 0; i < LINE_W; i++) begin
      h[IDX_W'((5 * i + 3) % IDX_W)] ^= line[i];
    end
    return h;
  endfunction

  logic [FILT_BITS-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits_q <= '0;
    end else if (clr_i) begin
      bits_q <= '0;
    end else if (ins_valid_i) begin
      bits_q[hash_a(ins_line_i)] <= 1'b1;
      bits_q[hash_b(ins_line_i)] <= 1'b1;
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_qry
    assign hit_o[q] = bits_q[hash_a(qry_line_i[q])] && bits_q[hash_b(qry_line_i[q])];
  end

  assign occupied_o = |bits_q;

endmodule

// File: rtl/ccu_chunk_ctr.sv
module ccu_chunk_ctr #(
  parameter int CS_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            retire_i,
  input  logic            end_i,
  output logic            at_max_o,
  output logic            ovf_o,
  output logic [CS_W-1:0] size_now_o
);

  localparam logic [CS_W-1:0] CNT_MAX = '1;

  // Size credited to the chunk that ends this cycle.
  function automatic logic [CS_W-1:0] credited(input logic [CS_W-1:0] c,
                                               input logic r);
    if (r && c == CNT_MAX) return c;
    return c + CS_W'(r);
  endfunction

  // Count carried into the following cycle.
  function automatic logic [CS_W-1:0] next_cnt(input logic [CS_W-1:0] c,
                                               input logic r,
                                               input logic e);
    if (e) return (r && c == CNT_MAX) ? CS_W'(1) : '0;
    return c + CS_W'(r);
  endfunction

  logic [CS_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= next_cnt(cnt_q, retire_i, end_i);
  end

  assign at_max_o   = (cnt_q == CNT_MAX);
  assign ovf_o      = retire_i && at_max_o;
  assign size_now_o = credited(cnt_q, retire_i);

endmodule

// File: rtl/ccu_term_arb.sv
module ccu_term_arb
  import ccu_pkg::*;
(
  input  logic    snp_valid_i,
  input  logic    snp_write_i,
  input  logic    snp_r_hit_i,
  input  logic    snp_w_hit_i,
  input  logic    ev_hit_i,
  input  logic    exc_i,
  input  logic    tlb_i,
  input  logic    req_i,
  input  logic    ovf_i,
  output logic    snp_conf_o,
  output logic    fire_o,
  output reason_e reason_o
);

  reason_e snp_r;

  always_comb begin
    snp_r = RSN_NONE;
    if (snp_valid_i) snp_r = snoop_reason(snp_write_i, snp_r_hit_i, snp_w_hit_i);
    reason_o   = pick_reason(snp_r, ev_hit_i, exc_i, tlb_i, req_i, ovf_i);
    snp_conf_o = (snp_r != RSN_NONE);
    fire_o     = (reason_o != RSN_NONE);
  end

endmodule

// File: rtl/chunk_conflict_unit.sv
module chunk_conflict_unit
  import ccu_pkg::*;
#(
  parameter int LINE_W    = 26,
  parameter int FILT_BITS = 512,
  parameter int CS_W      = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid_i,
  input  logic [LINE_W-1:0] ld_line_i,
  input  logic              st_valid_i,
  input  logic [LINE_W-1:0] st_line_i,
  input  logic              retire_i,
  input  logic              snp_valid_i,
  input  logic              snp_write_i,
  input  logic [LINE_W-1:0] snp_line_i,
  input  logic              evict_valid_i,
  input  logic [LINE_W-1:0] evict_line_i,
  input  logic              exc_i,
  input  logic              tlb_inval_i,
  input  logic              end_req_i,
  output logic              term_o,
  output logic [3:0]        reason_o,
  output logic [CS_W-1:0]   size_o
);

  localparam int NQ    = 2;   // lookup ports
  localparam int Q_SNP = 0;
  localparam int Q_EVT = 1;
  localparam int NSET  = 2;   // set 0 = reads, set 1 = writes
  localparam int S_RD  = 0;
  localparam int S_WR  = 1;

  logic [NSET-1:0]              set_vld;
  logic [NSET-1:0][LINE_W-1:0]  set_line;
  logic [NQ-1:0][LINE_W-1:0]    qry_line;
  logic [NSET-1:0]              pend_v;
  logic [NSET-1:0][LINE_W-1:0]  pend_l;
  logic [NSET-1:0][NQ-1:0]      stage_hit;
  logic [NSET-1:0][NQ-1:0]      filt_hit;
  logic [NSET-1:0][NQ-1:0]      any_hit;
  logic [NSET-1:0]              set_occ;

  // Named events for the checker
  logic            snp_r_hit_w;
  logic            snp_w_hit_w;
  logic            evict_conf_w;
  logic            snp_conf_w;
  logic            sys_any_w;
  logic            term_fire_w;
  logic            ovf_w;
  logic            cnt_at_max_w;
  logic [CS_W-1:0] size_now_w;
  logic            rd_occ_w;
  logic            wr_occ_w;
  reason_e         reason_w;

  assign set_vld[S_RD]  = ld_valid_i;
  assign set_vld[S_WR]  = st_valid_i;
  assign set_line[S_RD] = ld_line_i;
  assign set_line[S_WR] = st_line_i;
  assign qry_line[Q_SNP] = snp_line_i;
  assign qry_line[Q_EVT] = evict_line_i;

  for (genvar s = 0; s < NSET; s++) begin : g_set
    ccu_addr_stage #(
      .LINE_W (LINE_W),
      .NQ     (NQ)
    ) u_stage (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid_i   (set_vld[s]),
      .in_line_i    (set_line[s]),
      .qry_line_i   (qry_line),
      .pend_valid_o (pend_v[s]),
      .pend_line_o  (pend_l[s]),
      .hit_o        (stage_hit[s])
    );

    ccu_bloom #(
      .LINE_W    (LINE_W),
      .FILT_BITS (FILT_BITS),
      .NQ        (NQ)
    ) u_filt (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (term_fire_w),
      .ins_valid_i (pend_v[s]),
      .ins_line_i  (pend_l[s]),
      .qry_line_i  (qry_line),
      .hit_o       (filt_hit[s]),
      .occupied_o  (set_occ[s])
    );

    assign any_hit[s] = stage_hit[s] | filt_hit[s];
  end

  assign rd_occ_w     = set_occ[S_RD];
  assign wr_occ_w     = set_occ[S_WR];
  assign snp_r_hit_w  = snp_valid_i && any_hit[S_RD][Q_SNP];
  assign snp_w_hit_w  = snp_valid_i && any_hit[S_WR][Q_SNP];
  assign evict_conf_w = evict_valid_i && (any_hit[S_RD][Q_EVT] || any_hit[S_WR][Q_EVT]);
  assign sys_any_w    = exc_i || tlb_inval_i || end_req_i;

  ccu_chunk_ctr #(
    .CS_W (CS_W)
  ) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .retire_i   (retire_i),
    .end_i      (term_fire_w),
    .at_max_o   (cnt_at_max_w),
    .ovf_o      (ovf_w),
    .size_now_o (size_now_w)
  );

  ccu_term_arb u_arb (
    .snp_valid_i (snp_valid_i),
    .snp_write_i (snp_write_i),
    .snp_r_hit_i (snp_r_hit_w),
    .snp_w_hit_i (snp_w_hit_w),
    .ev_hit_i    (evict_conf_w),
    .exc_i       (exc_i),
    .tlb_i       (tlb_inval_i),
    .req_i       (end_req_i),
    .ovf_i       (ovf_w),
    .snp_conf_o  (snp_conf_w),
    .fire_o      (term_fire_w),
    .reason_o    (reason_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      term_o   <= 1'b0;
      reason_o <= 4'd0;
      size_o   <= '0;
    end else begin
      term_o   <= term_fire_w;
      reason_o <= term_fire_w ? 4'(reason_w) : 4'd0;
      size_o   <= term_fire_w ? size_now_w : '0;
    end
  end

endmodule

// File: rtl/ccu_checker.sv
module ccu_checker #(
  parameter int CS_W = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic            term_o,
  input logic [3:0]      reason_o,
  input logic [CS_W-1:0] size_o,
  input logic            snp_conf_w,
  input logic            evict_conf_w,
  input logic            sys_any_w,
  input logic            exc_i,
  input logic            retire_i,
  input logic            cnt_at_max_w,
  input logic            term_fire_w,
  input logic            rd_occ_w,
  input logic            wr_occ_w
);

  localparam logic [CS_W-1:0] CNT_MAX = '1;

  assert_quiet_outputs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !term_o |-> (reason_o == 4'd0 && size_o == '0));

  assert_known_reason_R11: assert property (@(posedge clk) disable iff (!rst_n)
    term_o |-> (reason_o >= 4'd1 && reason_o <= 4'd9));

  assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_conf_w || evict_conf_w || sys_any_w || (cnt_at_max_w && retire_i)) |=> !term_o);

  assert_conflict_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_conf_w |=> (term_o && reason_o >= 4'd1 && reason_o <= 4'd4));

  assert_evict_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_conf_w && !snp_conf_w) |=> (term_o && reason_o == 4'd5));

  assert_exception_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_i && !snp_conf_w && !evict_conf_w) |=> (term_o && reason_o == 4'd6));

  assert_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_at_max_w && retire_i) |=> (term_o && size_o == CNT_MAX));

  assert_sets_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    term_fire_w |=> (!rd_occ_w && !wr_occ_w));

endmodule

bind chunk_conflict_unit ccu_checker #(.CS_W(CS_W)) i_ccu_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .term_o       (term_o),
  .reason_o     (reason_o),
  .size_o       (size_o),
  .snp_conf_w   (snp_conf_w),
  .evict_conf_w (evict_conf_w),
  .sys_any_w    (sys_any_w),
  .exc_i        (exc_i),
  .retire_i     (retire_i),
  .cnt_at_max_w (cnt_at_max_w),
  .term_fire_w  (term_fire_w),
  .rd_occ_w     (rd_occ_w),
  .wr_occ_w     (wr_occ_w)
);

// File: tb/test_chunk_conflict_unit.sv
module test_chunk_conflict_unit;

  localparam int LW   = 26;
  localparam int CSW  = 4;
  localparam int NV   = 21;

  // Op codes of the table: 0 none, 1 read snoop, 2 write snoop, 3 evict,
  // 4 exception, 5 TLB invalidation, 6 explicit end
  // Lines chosen so their two filter positions never alias one another.
  localparam logic [LW-1:0] LA = 26'd1;
  localparam logic [LW-1:0] LB = 26'd2;
  localparam logic [LW-1:0] LC = 26'd4;
  localparam logic [LW-1:0] LE = 26'd16;

  function automatic logic [40:0] mk(input logic ld, input logic st, input logic ret,
                                     input logic [2:0] op, input logic [LW-1:0] line,
                                     input logic [3:0] rsn, input logic [4:0] sz);
    return {ld, st, ret, op, line, rsn, sz};
  endfunction

  localparam logic [40:0] VEC [NV] = '{
    mk(1,0,1,0,LA,0,0),  // R1 load A
    mk(0,0,1,0,LA,0,0),  // R8 count
    mk(0,0,0,1,LA,0,0),  // R3 read snoop hitting read set only: ignored
    mk(0,0,0,2,LA,2,2),  // R4 write after read, R8 size 2
    mk(0,0,0,2,LA,0,0),  // R10 sets were emptied
    mk(0,1,1,0,LB,0,0),  // R2 store B
    mk(0,0,0,1,LB,1,1),  // R3 R2 hit on held line only
    mk(1,1,1,0,LC,0,0),  // R1 R2 load and store C
    mk(0,0,0,0,LC,0,0),
    mk(0,0,0,2,LC,4,1),  // R4 hits both sets
    mk(0,1,0,0,LE,0,0),
    mk(0,0,0,0,LE,0,0),
    mk(0,0,0,0,LE,0,0),
    mk(0,0,0,2,LE,3,0),  // R4 write after write
    mk(1,0,1,0,LA,0,0),
    mk(0,0,0,3,LB,0,0),  // R5 eviction miss
    mk(0,0,0,3,LA,5,1),  // R5 eviction hit
    mk(1,0,0,4,LB,6,0),  // R6 exception, R10 B enters new chunk
    mk(0,0,0,2,LB,2,0),  // R10 B kept across the end
    mk(0,0,1,5,LB,7,1),  // R6 TLB invalidation
    mk(0,0,1,6,LB,8,1)   // R6 explicit end
  };

  logic           clk = 1'b0;
  logic           rst_n;
  logic           ld_valid, st_valid, retire, snp_valid, snp_write, evict_valid;
  logic           exc, tlb_inval, end_req;
  logic [LW-1:0]  ld_line, st_line, snp_line, evict_line;
  logic           term;
  logic [3:0]     reason;
  logic [CSW-1:0] size;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;   // 250 MHz

  chunk_conflict_unit #(.LINE_W(LW), .FILT_BITS(512), .CS_W(CSW)) i_chunk_conflict_unit (
    .clk(clk), .rst_n(rst_n),
    .ld_valid_i(ld_valid), .ld_line_i(ld_line),
    .st_valid_i(st_valid), .st_line_i(st_line),
    .retire_i(retire),
    .snp_valid_i(snp_valid), .snp_write_i(snp_write), .snp_line_i(snp_line),
    .evict_valid_i(evict_valid), .evict_line_i(evict_line),
    .exc_i(exc), .tlb_inval_i(tlb_inval), .end_req_i(end_req),
    .term_o(term), .reason_o(reason), .size_o(size)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<=20000", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic quiet();
    ld_valid = 0; st_valid = 0; retire = 0; snp_valid = 0; snp_write = 0;
    evict_valid = 0; exc = 0; tlb_inval = 0; end_req = 0;
    ld_line = '0; st_line = '0; snp_line = '0; evict_line = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input int rsn, input int sz);
    check({tag, " term"}, int'(term), int'(rsn != 0));
    check({tag, " reason"}, int'(reason), rsn);
    check({tag, " size"}, int'(size), sz);
  endtask

  initial begin
    quiet();
    rst_n = 0;
    @(negedge clk);
    step();
    step();
    // R12 reset state
    expect_out("R12 reset", 0, 0);
    rst_n = 1;

    for (int k = 0; k < NV; k++) begin
      logic [40:0] v;
      v = VEC[k];
      quiet();
      ld_valid = v[40];
      st_valid = v[39];
      retire   = v[38];
      ld_line = v[34:9]; st_line = v[34:9]; snp_line = v[34:9]; evict_line = v[34:9];
      case (v[37:35])
        3'd1: snp_valid = 1;
        3'd2: begin snp_valid = 1; snp_write = 1; end
        3'd3: evict_valid = 1;
        3'd4: exc = 1;
        3'd5: tlb_inval = 1;
        3'd6: end_req = 1;
        default: ;
      endcase
      step();
      expect_out($sformatf("table vector %0d", k), int'(v[8:5]), int'(v[4:0]));
    end

    // R7 every cause at once: snoop conflict wins, retire counted (R8)
    quiet(); ld_valid = 1; ld_line = LA; step();
    quiet(); step();
    quiet(); snp_valid = 1; snp_write = 1; snp_line = LA; evict_valid = 1; evict_line = LA;
    exc = 1; tlb_inval = 1; end_req = 1; retire = 1; step();
    expect_out("R7 conflict first", 2, 1);

    // R7 eviction over system events
    quiet(); ld_valid = 1; ld_line = LA; step();
    quiet(); step();
    quiet(); evict_valid = 1; evict_line = LA; exc = 1; tlb_inval = 1; step();
    expect_out("R7 eviction over events", 5, 0);

    // R6 ordering among system events
    quiet(); exc = 1; tlb_inval = 1; end_req = 1; step();
    expect_out("R6 exception first", 6, 0);
    quiet(); tlb_inval = 1; end_req = 1; step();
    expect_out("R6 tlb over explicit", 7, 0);

    // R1 a lookup in the insertion cycle misses, the next one hits
    quiet(); ld_valid = 1; ld_line = LB; snp_valid = 1; snp_write = 1; snp_line = LB; step();
    expect_out("R1 same-cycle lookup", 0, 0);
    quiet(); snp_valid = 1; snp_write = 1; snp_line = LB; step();
    expect_out("R1 held line visible", 2, 0);

    // R9 overflow at the counter limit
    for (int i = 0; i < 15; i++) begin
      quiet(); retire = 1; step();
    end
    expect_out("R8 counting to limit", 0, 0);
    quiet(); retire = 1; step();
    expect_out("R9 overflow", 9, 15);
    quiet(); end_req = 1; step();
    expect_out("R9 carried retirement", 8, 1);

    // R7 system event over overflow in the same cycle
    for (int i = 0; i < 15; i++) begin
      quiet(); retire = 1; step();
    end
    quiet(); retire = 1; end_req = 1; step();
    expect_out("R7 event over overflow", 8, 15);
    quiet(); end_req = 1; step();
    expect_out("R9 carry after shared end", 8, 1);

    // R12 reset in the middle of a chunk
    quiet(); ld_valid = 1; ld_line = LA; retire = 1; step();
    quiet(); step();
    rst_n = 0; step();
    rst_n = 1;
    expect_out("R12 mid-chunk reset", 0, 0);
    quiet(); snp_valid = 1; snp_write = 1; snp_line = LA; step();
    expect_out("R12 sets empty after reset", 0, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule